// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Plane

This block is the logic core of a small programmable logic device. Ten dedicated inputs and eight feedback signals are each presented to the array in true and in inverted form. Each product term is the AND of whichever of these lines a stored connection bit attaches to it. The term set is fixed at 74 terms. Sixty-four of them feed the OR plane in eight fixed groups of eight, one group for each sum output. Eight further terms serve as per-output enable terms. The last two form a global synchronous preset term and a global asynchronous clear term. Output macrocells and pin drivers are outside this block and consume these signals.

The connection store is written through a serial shift port, one bit per line/term intersection. A single-cycle erase opens every connection. The planes themselves are purely combinational from the stored bits and the live inputs. A one-cycle-delayed busy flag reports any configuration activity.

Top module: `sop_array`

## Requirements
- R1: Signal s (0..9 = `ded_in[s]`, 10..17 = `fb_in[s-10]`) drives array line 2s with its true value and line 2s+1 with its inverted value, giving 36 lines.
- R2: The connection for term t and line l is store bit k = t*36 + l, with 1 meaning connected. Each clock edge with `cfg_load` high and `cfg_erase` low moves every stored bit from index k to k-1 and places `cfg_bit` at index 2663. After 2664 such shifts, the first bit sent sits at k = 0.
- R3: A product term with no connections evaluates to 1.
- R4: A product term connected to both lines of one signal evaluates to 0, so it leaves its OR output unchanged.
- R5: Terms 8g..8g+7 (g = 0..7) are ORed into `sum_out[g]`. Term 64+k drives `oe_term[k]`, term 72 drives `preset_term` and term 73 drives `clear_term`.
- R6: All term and sum outputs follow `ded_in`/`fb_in` in the same cycle, with no register on the path.
- R7: An edge with `cfg_erase` high opens every connection. This holds even when `cfg_load` is also high, in which case the shifted bit is discarded.
- R8: `cfg_busy` is 1 in the cycle after any edge at which `cfg_load` or `cfg_erase` was high, and 0 otherwise.
- R9: At an edge with both `cfg_load` and `cfg_erase` low, `cfg_bit` is ignored and all connections are kept.
- R10: A synchronous active-high `rst` opens every connection and clears `cfg_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Shift enable for the connection store |
| cfg_erase | input | 1 | Open every connection at the next edge |
| cfg_bit | input | 1 | Serial connection bit |
| ded_in | input | 10 | Dedicated inputs |
| fb_in | input | 8 | Feedback signals |
| sum_out | output | 8 | OR of each group of eight sum terms |
| oe_term | output | 8 | Per-output enable terms |
| preset_term | output | 1 | Global synchronous preset term |
| clear_term | output | 1 | Global asynchronous clear term |
| cfg_busy | output | 1 | Configuration activity in the previous edge |

## Verification
Erase and shift can be requested at the same edge. The bench provokes this by raising `cfg_erase` and `cfg_load` together with `cfg_bit` at 1, while `fb_in[7]` is high. If the shifted bit survived, it would connect the inverted feedback-7 line to the clear term and drive `clear_term` low. The pass condition is that every output reads as an open term afterwards and that `cfg_busy` is high for exactly one cycle.

// File: rtl/sop_pkg.sv
package sop_pkg;
    localparam int N_DED     = 10;
    localparam int N_FB      = 8;
    localparam int N_SIG     = N_DED + N_FB;
    localparam int N_LINE    = 2 * N_SIG;
    localparam int N_GRP     = 8;
    localparam int GRP_TERMS = 8;
    localparam int N_SUM_T   = N_GRP * GRP_TERMS;
    localparam int N_OE      = N_GRP;
    localparam int N_TERM    = N_SUM_T + N_OE + 2;
    localparam int IDX_PRE   = N_SUM_T + N_OE;
    localparam int IDX_CLR   = N_SUM_T + N_OE + 1;
    localparam int CFG_BITS  = N_TERM * N_LINE;

    typedef struct packed {
        logic [N_OE-1:0] oe;
        logic            preset;
        logic            clear;
    } ctrl_t;

    // R1: even line = true value, odd line = inverted value
    function automatic logic [N_LINE-1:0] make_lines(
        input logic [N_DED-1:0] ded,
        input logic [N_FB-1:0]  fb
    );
        logic [N_SIG-1:0]  sig;
        logic [N_LINE-1:0] ln;
        sig = {fb, ded};
        for (int s = 0; s < N_SIG; s++) begin
            ln[2*s]   = sig[s];
            ln[2*s+1] = ~sig[s];
        end
        return ln;
    endfunction

    function automatic logic has_contra(input logic [N_LINE-1:0] row);
        logic c;
        c = 1'b0;
        for (int s = 0; s < N_SIG; s++)
            c = c | (row[2*s] & row[2*s+1]);
        return c;
    endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
    parameter int BITS = sop_pkg::CFG_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            erase,
    input  logic            bit_in,
    output logic [BITS-1:0] conn,
    output logic            busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            conn <= '0;
            busy <= 1'b0;
        end else begin
            busy <= load | erase;
            if (erase)
                conn <= '0;
            else if (load)
                conn <= {bit_in, conn[BITS-1:1]};
        end
    end

    a_r2_shift: assert property (@(posedge clk) disable iff (rst)
        (load && !erase) |=> (conn[BITS-1] == $past(bit_in)) &&
                             (conn[BITS-2:0] == $past(conn[BITS-1:1])));
    a_r7_erase_open: assert property (@(posedge clk) disable iff (rst)
        erase |=> (conn == '0));
    a_r8_busy_set: assert property (@(posedge clk) disable iff (rst)
        (load || erase) |=> busy);
    a_r8_busy_clr: assert property (@(posedge clk) disable iff (rst)
        (!load && !erase) |=> !busy);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !erase) |=> $stable(conn));
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (conn == '0) && !busy);
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_TERM = sop_pkg::N_TERM,
    parameter int N_LINE = sop_pkg::N_LINE,
    localparam int BITS  = N_TERM * N_LINE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_LINE-1:0] lines,
    input  logic [BITS-1:0]   conn,
    output logic [N_TERM-1:0] terms
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_LINE-1:0] row;
        assign row      = conn[t*N_LINE +: N_LINE];
        // unconnected lines are forced true, so an empty row yields 1
        assign terms[t] = &(lines | ~row);

        a_r3_open_true: assert property (@(posedge clk) disable iff (rst)
            (row == '0) |-> terms[t]);
        a_r4_contra_false: assert property (@(posedge clk) disable iff (rst)
            sop_pkg::has_contra(row) |-> !terms[t]);
    end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_GRP     = sop_pkg::N_GRP,
    parameter int GRP_TERMS = sop_pkg::GRP_TERMS,
    localparam int N_IN     = N_GRP * GRP_TERMS
) (
    input  logic [N_IN-1:0]  sum_terms,
    output logic [N_GRP-1:0] sums
);
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign sums[g] = |sum_terms[g*GRP_TERMS +: GRP_TERMS];
    end
endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic             cfg_erase,
    input  logic             cfg_bit,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_FB-1:0]  fb_in,
    output logic [N_GRP-1:0] sum_out,
    output logic [N_OE-1:0]  oe_term,
    output logic             preset_term,
    output logic             clear_term,
    output logic             cfg_busy
);
    logic [CFG_BITS-1:0] conn;
    logic [N_LINE-1:0]   lines;
    logic [N_TERM-1:0]   terms;
    ctrl_t               ctrl;

    sop_cfg_store #(.BITS(CFG_BITS)) u_store (
        .clk    (clk),
        .rst    (rst),
        .load   (cfg_load),
        .erase  (cfg_erase),
        .bit_in (cfg_bit),
        .conn   (conn),
        .busy   (cfg_busy)
    );

    assign lines = make_lines(ded_in, fb_in);

    sop_and_plane #(.N_TERM(N_TERM), .N_LINE(N_LINE)) u_and (
        .clk   (clk),
        .rst   (rst),
        .lines (lines),
        .conn  (conn),
        .terms (terms)
    );

    sop_or_plane #(.N_GRP(N_GRP), .GRP_TERMS(GRP_TERMS)) u_or (
        .sum_terms (terms[N_SUM_T-1:0]),
        .sums      (sum_out)
    );

    assign ctrl.oe     = terms[N_SUM_T +: N_OE];
    assign ctrl.preset = terms[IDX_PRE];
    assign ctrl.clear  = terms[IDX_CLR];

    assign oe_term     = ctrl.oe;
    assign preset_term = ctrl.preset;
    assign clear_term  = ctrl.clear;

    a_r7_erased_outputs: assert property (@(posedge clk) disable iff (rst)
        cfg_erase |=> (&sum_out) && (&oe_term) && preset_term && clear_term);
endmodule

// File: tb/tb_sop_array.sv
`timescale 1ns/1ps
module tb_sop_array;
    import sop_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_load, cfg_erase, cfg_bit;
    logic [N_DED-1:0] ded_in;
    logic [N_FB-1:0]  fb_in;
    logic [N_GRP-1:0] sum_out;
    logic [N_OE-1:0]  oe_term;
    logic             preset_term, clear_term, cfg_busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sop_array dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_erase(cfg_erase),
        .cfg_bit(cfg_bit), .ded_in(ded_in), .fb_in(fb_in), .sum_out(sum_out),
        .oe_term(oe_term), .preset_term(preset_term), .clear_term(clear_term),
        .cfg_busy(cfg_busy)
    );

    // stimulus vectors {fb, ded}
    localparam logic [17:0] STIM [0:11] = '{
        18'h00000, 18'h3FFFF, 18'h00003, 18'h00404, 18'h00008,
        18'h201C0, 18'h00220, 18'h20000, 18'h10001, 18'h00200,
        18'h15555, 18'h2AAAA
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int tl(input int s); return 2*s;   endfunction
    function automatic int cl(input int s); return 2*s+1; endfunction

    function automatic logic [CFG_BITS-1:0] build_a();
        logic [CFG_BITS-1:0] v;
        v = '0;
        v[0*N_LINE+tl(0)] = 1'b1; v[0*N_LINE+tl(1)] = 1'b1;
        v[1*N_LINE+cl(2)] = 1'b1; v[1*N_LINE+tl(10)] = 1'b1;
        v[8*N_LINE+tl(3)] = 1'b1; v[8*N_LINE+cl(4)] = 1'b1;
        v[24*N_LINE+tl(17)] = 1'b1;
        v[64*N_LINE+tl(9)] = 1'b1;
        v[65*N_LINE+cl(11)] = 1'b1; v[65*N_LINE+tl(5)] = 1'b1;
        v[72*N_LINE+tl(6)] = 1'b1; v[72*N_LINE+tl(7)] = 1'b1; v[72*N_LINE+tl(8)] = 1'b1;
        v[73*N_LINE+cl(0)] = 1'b1; v[73*N_LINE+cl(16)] = 1'b1;
        // contradictory fillers (R4)
        for (int t = 2; t < 32; t++)
            if (t != 8 && t != 24) begin
                v[t*N_LINE+tl(0)] = 1'b1; v[t*N_LINE+cl(0)] = 1'b1;
            end
        v[66*N_LINE+tl(3)] = 1'b1; v[66*N_LINE+cl(3)] = 1'b1;
        return v;
    endfunction

    // {sum[7:0], oe[7:0], preset, clear}
    function automatic logic [17:0] model_a(input logic [9:0] d, input logic [7:0] f);
        logic [7:0] s, o;
        s = 8'hF0;
        s[0] = (d[0] & d[1]) | (~d[2] & f[0]);
        s[1] = d[3] & ~d[4];
        s[2] = 1'b0;
        s[3] = f[7];
        o = 8'hF8;
        o[0] = d[9];
        o[1] = ~f[1] & d[5];
        o[2] = 1'b0;
        return {s, o, d[6] & d[7] & d[8], ~d[0] & ~f[6]};
    endfunction

    function automatic logic [17:0] outs();
        return {sum_out, oe_term, preset_term, clear_term};
    endfunction

    task automatic load_cfg(input logic [CFG_BITS-1:0] v);
        for (int k = 0; k < CFG_BITS; k++) begin
            @(negedge clk);
            if (k == 1) chk("R8 busy during load", cfg_busy, 1);
            cfg_load = 1'b1;
            cfg_bit  = v[k];
        end
        @(negedge clk);
        chk("R8 busy after last shift", cfg_busy, 1);
        cfg_load = 1'b0;
        cfg_bit  = 1'b0;
        @(negedge clk);
        chk("R8 busy drops", cfg_busy, 0);
    endtask

    task automatic apply(input logic [17:0] p, input string req);
        ded_in = p[9:0];
        fb_in  = p[17:10];
        #1;
        chk(req, outs(), model_a(p[9:0], p[17:10]));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_load = 1'b0; cfg_erase = 1'b0; cfg_bit = 1'b0;
        ded_in = '0; fb_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 / R3: reset leaves every term open
        chk("R10 busy after reset", cfg_busy, 0);
        chk("R10 R3 open terms after reset", outs(), 18'h3FFFF);
        rst = 1'b0;

        // R2 R5: serial load of a known pattern
        load_cfg(build_a());

        // R1 R4 R5 R6: vector walk, same-cycle combinational response
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            apply(STIM[i], "R1 R5 R6 vector");
        end

        // R4: group 2 made only of contradictory terms stays 0, group 0 at 0 when its real terms are false
        @(negedge clk);
        apply(18'h00404, "R4 contradictions");
        chk("R4 group2 zero", sum_out[2], 0);
        chk("R4 group0 zero", sum_out[0], 0);

        // R9: cfg_bit toggles with load and erase low
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cfg_bit = i[0];
            ded_in = 10'h2C3; fb_in = 8'h81;
            #1;
            chk("R9 cfg_bit ignored", outs(), model_a(10'h2C3, 8'h81));
            chk("R9 busy idle", cfg_busy, 0);
        end
        cfg_bit = 1'b0;

        // R7: plain erase
        @(negedge clk);
        cfg_erase = 1'b1;
        @(negedge clk);
        cfg_erase = 1'b0;
        chk("R7 erase opens all", outs(), 18'h3FFFF);
        chk("R8 busy after erase", cfg_busy, 1);
        @(negedge clk);
        chk("R8 busy clears after erase", cfg_busy, 0);

        // R7: erase and load together, erase wins
        load_cfg(build_a());
        @(negedge clk);
        ded_in = 10'h000; fb_in = 8'h80;
        #1;
        chk("R2 reload effective", outs(), model_a(10'h000, 8'h80));
        @(negedge clk);
        cfg_erase = 1'b1; cfg_load = 1'b1; cfg_bit = 1'b1;
        @(negedge clk);
        cfg_erase = 1'b0; cfg_load = 1'b0; cfg_bit = 1'b0;
        chk("R7 erase beats load", outs(), 18'h3FFFF);
        chk("R8 busy one cycle", cfg_busy, 1);
        @(negedge clk);
        chk("R8 busy low again", cfg_busy, 0);

        // R10: reset after a load opens connections
        load_cfg(build_a());
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ded_in = 10'h000; fb_in = 8'h00;
        #1;
        chk("R10 reset opens connections", outs(), 18'h3FFFF);

        finish_run();
    end
endmodule